// File: doc/BRIEF.md
# Stream-to-Memory DMA Write Engine

This block moves words arriving on one of several device streams into memory without per-word processor work. Software loads a physical start address and a word count, then writes a control word. The control word picks the input stream, enables the interrupt and sets the run flag. From then on the engine takes one word at a time from the chosen stream. It writes each word to memory with a request/grant handshake and steps the address and the count after every accepted write. It stops when the count runs out, when memory answers with an error, or when software clears the run flag. The interrupt line rises on completion or on error, provided the interrupt is enabled. No address translation is done: the address goes to memory exactly as programmed.

Registers are selected by a two-bit word index. Index 0 holds the current address, index 1 the remaining count and index 2 the control word. In the control word, bit 0 is run, bit 1 is interrupt enable and bits 3:2 are the source select. Index 3 is status: bit 0 busy, bit 1 done, bit 2 error. Reads are combinational.

A three-state machine sequences the transfer. IDLE goes to FETCH on a start with a nonzero count. FETCH goes to WRITE when the selected stream offers a word, and goes back to IDLE as an abort when run has been cleared. WRITE stays put until grant. It then goes to FETCH when words remain and run is still set. It returns to IDLE on an error response, on the last word, or on an abort that is pending.

Top module: `dmaw_engine`

## Requirements
- R1: After reset every register reads zero, and irq, mem_req and all dev_ready bits are low.
- R2: A write to index 2 with bit 0 set while idle starts a transfer if the count is nonzero, and clears done and error.
- R3: Only the stream named by control bits 3:2 ever sees dev_ready, and only while the engine waits for a word and has no write pending. A word is taken when valid and ready are both high.
- R4: mem_req stays high with mem_addr and mem_wdata unchanged until mem_gnt. The i-th write (from 0) carries address base+4*i and the i-th word taken.
- R5: Each write granted without error adds 4 to the address register and subtracts 1 from the count register.
- R6: When the count reaches zero the engine goes idle, sets done (status bit 1) and clears the run bit.
- R7: mem_err in a grant cycle ends the transfer at once and sets error (status bit 2). Address and count stay as they were before that write, and no further request follows.
- R8: A start with a count of zero sets done in the same edge and makes no memory write.
- R9: Writes to index 0 or index 1 while busy change nothing.
- R10: Clearing run while busy lets any pending write finish, takes no new word, then sets done with the remaining count left visible.
- R11: Writing 1 to status bit 1 or bit 2 clears that bit. A set event in the same cycle takes priority over the clear.
- R12: irq is high exactly when (done or error) and interrupt enable are all set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_idx | input | 2 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_idx |
| dev_valid | input | NUM_SRC | Word offered, one bit per stream |
| dev_data | input | NUM_SRC*DATA_W | Stream words, stream s in slice s |
| dev_ready | output | NUM_SRC | Word accepted, one bit per stream |
| mem_req | output | 1 | Memory write request |
| mem_addr | output | ADDR_W | Memory write address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_gnt | input | 1 | Memory grant; write completes when high with mem_req |
| mem_err | input | 1 | Error response, valid in the grant cycle |
| irq | output | 1 | Interrupt request |

## Verification
A write's grant can land on the same clock edge as a software write to status that clears done and error. The bench holds grant off until a single-word transfer is waiting, then presents grant and a status write of both clear bits together. It expects done to read back as 1 with irq still high. A second collision is an abort against a pending write. Run is cleared while grants are slow, and the bench judges the outcome by matching the words consumed against the writes made and checking that the remaining count equals the programmed count minus the writes.

// File: rtl/dmaw_pkg.sv
package dmaw_pkg;

    localparam int REG_W = 32;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_FETCH = 2'd1,
        S_WRITE = 2'd2
    } dmaw_state_e;

    localparam logic [1:0] IDX_ADDR = 2'd0;
    localparam logic [1:0] IDX_CNT  = 2'd1;
    localparam logic [1:0] IDX_CTL  = 2'd2;
    localparam logic [1:0] IDX_STAT = 2'd3;

    localparam int CTL_RUN     = 0;
    localparam int CTL_IE      = 1;
    localparam int CTL_SRC_LSB = 2;

    localparam int ST_BUSY = 0;
    localparam int ST_DONE = 1;
    localparam int ST_ERR  = 2;

endpackage

// File: rtl/dmaw_regs.sv
module dmaw_regs
    import dmaw_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16,
    parameter int SEL_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [1:0]        reg_idx,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              busy,
    input  logic              adv,
    input  logic              fin_done,
    input  logic              fin_err,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              run,
    output logic [SEL_W-1:0]  src_sel,
    output logic              start,
    output logic              cnt_zero,
    output logic              cnt_one,
    output logic              irq
);

    logic [CNT_W-1:0] cnt_q;
    logic             ie_q;
    logic             done_q;
    logic             err_q;
    logic             wr_addr;
    logic             wr_cnt;
    logic             wr_ctl;
    logic             wr_stat;

    assign wr_addr  = reg_wr && (reg_idx == IDX_ADDR);
    assign wr_cnt   = reg_wr && (reg_idx == IDX_CNT);
    assign wr_ctl   = reg_wr && (reg_idx == IDX_CTL);
    assign wr_stat  = reg_wr && (reg_idx == IDX_STAT);
    assign cnt_zero = (cnt_q == '0);
    assign cnt_one  = (cnt_q == CNT_W'(1));
    assign start    = wr_ctl && reg_wdata[CTL_RUN] && !busy;
    assign irq      = (done_q || err_q) && ie_q;

    // Address: software load only when idle, hardware step per good write.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_addr <= '0;
        end else if (wr_addr && !busy) begin
            cur_addr <= reg_wdata[ADDR_W-1:0];
        end else if (adv) begin
            cur_addr <= cur_addr + ADDR_W'(4);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (wr_cnt && !busy) begin
            cnt_q <= reg_wdata[CNT_W-1:0];
        end else if (adv) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    // Control: full write when idle; while busy run may only be cleared.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run     <= 1'b0;
            ie_q    <= 1'b0;
            src_sel <= '0;
        end else begin
            if (wr_ctl && !busy) begin
                run     <= reg_wdata[CTL_RUN] && !cnt_zero;
                ie_q    <= reg_wdata[CTL_IE];
                src_sel <= reg_wdata[CTL_SRC_LSB +: SEL_W];
            end else if (wr_ctl) begin
                run  <= run && reg_wdata[CTL_RUN];
                ie_q <= reg_wdata[CTL_IE];
            end
            if (busy && (fin_done || fin_err)) begin
                run <= 1'b0;
            end
        end
    end

    // Sticky flags: start or write-one clears, hardware events set last.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            if (start) begin
                done_q <= 1'b0;
                err_q  <= 1'b0;
            end else if (wr_stat) begin
                done_q <= done_q && !reg_wdata[ST_DONE];
                err_q  <= err_q && !reg_wdata[ST_ERR];
            end
            if (fin_done) begin
                done_q <= 1'b1;
            end
            if (fin_err) begin
                err_q <= 1'b1;
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_idx)
            IDX_ADDR: reg_rdata = REG_W'(cur_addr);
            IDX_CNT:  reg_rdata = REG_W'(cnt_q);
            IDX_CTL: begin
                reg_rdata[CTL_RUN]                = run;
                reg_rdata[CTL_IE]                 = ie_q;
                reg_rdata[CTL_SRC_LSB +: SEL_W]   = src_sel;
            end
            IDX_STAT: begin
                reg_rdata[ST_BUSY] = busy;
                reg_rdata[ST_DONE] = done_q;
                reg_rdata[ST_ERR]  = err_q;
            end
            default: reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/dmaw_src_mux.sv
module dmaw_src_mux #(
    parameter int NUM_SRC = 4,
    parameter int DATA_W  = 32,
    parameter int SEL_W   = 2
) (
    input  logic [SEL_W-1:0]          sel,
    input  logic                      ready_in,
    input  logic [NUM_SRC-1:0]        dev_valid,
    input  logic [NUM_SRC*DATA_W-1:0] dev_data,
    output logic [NUM_SRC-1:0]        dev_ready,
    output logic                      sel_valid,
    output logic [DATA_W-1:0]         sel_data
);

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_ready
        assign dev_ready[g] = ready_in && (sel == SEL_W'(g));
    end

    always_comb begin
        sel_valid = 1'b0;
        sel_data  = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (sel == SEL_W'(i)) begin
                sel_valid = dev_valid[i];
                sel_data  = dev_data[i*DATA_W +: DATA_W];
            end
        end
    end

endmodule

// File: rtl/dmaw_fsm.sv
module dmaw_fsm
    import dmaw_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              cnt_zero,
    input  logic              cnt_one,
    input  logic              run,
    input  logic              sel_valid,
    input  logic [DATA_W-1:0] sel_data,
    output logic              sel_ready,
    input  logic              mem_gnt,
    input  logic              mem_err,
    output logic              mem_req,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              adv,
    output logic              fin_done,
    output logic              fin_err,
    output logic              busy
);

    dmaw_state_e      state_q;
    dmaw_state_e      state_d;
    logic [DATA_W-1:0] data_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (start && !cnt_zero) state_d = S_FETCH;
            end
            S_FETCH: begin
                if (!run)           state_d = S_IDLE;
                else if (sel_valid) state_d = S_WRITE;
            end
            S_WRITE: begin
                if (mem_gnt) begin
                    if (mem_err || cnt_one || !run) state_d = S_IDLE;
                    else                            state_d = S_FETCH;
                end
            end
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (sel_ready && sel_valid) begin
            data_q <= sel_data;
        end
    end

    always_comb begin
        sel_ready = 1'b0;
        mem_req   = 1'b0;
        adv       = 1'b0;
        fin_done  = 1'b0;
        fin_err   = 1'b0;
        busy      = 1'b1;
        unique case (state_q)
            S_IDLE: begin
                busy     = 1'b0;
                fin_done = start && cnt_zero;
            end
            S_FETCH: begin
                sel_ready = run;
                fin_done  = !run;
            end
            S_WRITE: begin
                mem_req  = 1'b1;
                adv      = mem_gnt && !mem_err;
                fin_err  = mem_gnt && mem_err;
                fin_done = mem_gnt && !mem_err && (cnt_one || !run);
            end
            default: busy = 1'b0;
        endcase
    end

    assign mem_wdata = data_q;

endmodule

// File: rtl/dmaw_engine.sv
module dmaw_engine
    import dmaw_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int DATA_W  = 32,
    parameter int CNT_W   = 16,
    parameter int NUM_SRC = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      reg_wr,
    input  logic [1:0]                reg_idx,
    input  logic [31:0]               reg_wdata,
    output logic [31:0]               reg_rdata,
    input  logic [NUM_SRC-1:0]        dev_valid,
    input  logic [NUM_SRC*DATA_W-1:0] dev_data,
    output logic [NUM_SRC-1:0]        dev_ready,
    output logic                      mem_req,
    output logic [ADDR_W-1:0]         mem_addr,
    output logic [DATA_W-1:0]         mem_wdata,
    input  logic                      mem_gnt,
    input  logic                      mem_err,
    output logic                      irq
);

    localparam int SEL_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

    logic              busy;
    logic              adv;
    logic              fin_done;
    logic              fin_err;
    logic              run;
    logic              start;
    logic              cnt_zero;
    logic              cnt_one;
    logic [SEL_W-1:0]  src_sel;
    logic              sel_ready;
    logic              sel_valid;
    logic [DATA_W-1:0] sel_data;

    dmaw_regs #(
        .ADDR_W (ADDR_W),
        .CNT_W  (CNT_W),
        .SEL_W  (SEL_W)
    ) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_idx   (reg_idx),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .busy      (busy),
        .adv       (adv),
        .fin_done  (fin_done),
        .fin_err   (fin_err),
        .cur_addr  (mem_addr),
        .run       (run),
        .src_sel   (src_sel),
        .start     (start),
        .cnt_zero  (cnt_zero),
        .cnt_one   (cnt_one),
        .irq       (irq)
    );

    dmaw_src_mux #(
        .NUM_SRC (NUM_SRC),
        .DATA_W  (DATA_W),
        .SEL_W   (SEL_W)
    ) mux_i (
        .sel       (src_sel),
        .ready_in  (sel_ready),
        .dev_valid (dev_valid),
        .dev_data  (dev_data),
        .dev_ready (dev_ready),
        .sel_valid (sel_valid),
        .sel_data  (sel_data)
    );

    dmaw_fsm #(
        .DATA_W (DATA_W)
    ) fsm_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .cnt_zero  (cnt_zero),
        .cnt_one   (cnt_one),
        .run       (run),
        .sel_valid (sel_valid),
        .sel_data  (sel_data),
        .sel_ready (sel_ready),
        .mem_gnt   (mem_gnt),
        .mem_err   (mem_err),
        .mem_req   (mem_req),
        .mem_wdata (mem_wdata),
        .adv       (adv),
        .fin_done  (fin_done),
        .fin_err   (fin_err),
        .busy      (busy)
    );

endmodule

// File: rtl/dmaw_engine_chk.sv
module dmaw_engine_chk #(
    parameter int ADDR_W  = 32,
    parameter int DATA_W  = 32,
    parameter int NUM_SRC = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               reg_wr,
    input logic [NUM_SRC-1:0] dev_ready,
    input logic               mem_req,
    input logic [ADDR_W-1:0]  mem_addr,
    input logic [DATA_W-1:0]  mem_wdata,
    input logic               mem_gnt,
    input logic               mem_err
);

    logic [ADDR_W-1:0] nxt_addr;
    logic              have_nxt;

    // Expected address of the next write inside one transfer.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            nxt_addr <= '0;
            have_nxt <= 1'b0;
        end else if (reg_wr) begin
            have_nxt <= 1'b0;
        end else if (mem_req && mem_gnt && !mem_err) begin
            nxt_addr <= mem_addr + ADDR_W'(4);
            have_nxt <= 1'b1;
        end
    end

    a_r3_ready_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dev_ready));

    a_r3_ready_excl: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_ready != '0) |-> !mem_req);

    a_r4_hold_write: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_wdata)));

    a_r5_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && have_nxt) |-> (mem_addr == nxt_addr));

    a_r7_err_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_gnt && mem_err) |=> (!mem_req && dev_ready == '0));

endmodule

bind dmaw_engine dmaw_engine_chk #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .NUM_SRC (NUM_SRC)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .dev_ready (dev_ready),
    .mem_req   (mem_req),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_gnt   (mem_gnt),
    .mem_err   (mem_err)
);

// File: tb/dmaw_engine_tb.sv
module dmaw_engine_tb_top;

    localparam int NS = 4;
    localparam int DW = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            reg_wr = 1'b0;
    logic [1:0]      reg_idx = '0;
    logic [31:0]     reg_wdata = '0;
    logic [31:0]     reg_rdata;
    logic [NS-1:0]   dev_valid = '0;
    logic [NS*DW-1:0] dev_data = '0;
    logic [NS-1:0]   dev_ready;
    logic            mem_req;
    logic [31:0]     mem_addr;
    logic [DW-1:0]   mem_wdata;
    logic            mem_gnt = 1'b0;
    logic            mem_err = 1'b0;
    logic            irq;

    int tests = 0;
    int fails = 0;
    int rd_idx = 0;
    int wr_idx = 0;
    int cur_src = 0;
    int err_at = -1;
    int gnt_pct = 100;
    int val_pct = 100;
    int stray = 0;
    bit force_gnt = 1'b0;
    logic [31:0] exp_base = '0;
    logic [31:0] words [0:63];

    always #5 clk = ~clk;

    dmaw_engine dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_idx(reg_idx),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dev_valid(dev_valid),
        .dev_data(dev_data), .dev_ready(dev_ready), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_gnt(mem_gnt),
        .mem_err(mem_err), .irq(irq)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] ctlword(int src, bit ie, bit run);
        return (32'(src) << 2) | (32'(ie) << 1) | 32'(run);
    endfunction

    // Device and memory model: drive at negedge, record handshakes just after.
    always @(negedge clk) begin
        if (!rst_n) begin
            dev_valid = '0;
            mem_gnt   = 1'b0;
            mem_err   = 1'b0;
        end else begin
            for (int s = 0; s < NS; s++) begin
                dev_data[s*DW +: DW] = $urandom;
                dev_valid[s] = ($urandom % 100) < 50;
            end
            dev_valid[cur_src] = (($urandom % 100) < val_pct) && (rd_idx < 64);
            dev_data[cur_src*DW +: DW] = words[rd_idx % 64];
            mem_gnt = force_gnt || (($urandom % 100) < gnt_pct);
            mem_err = mem_gnt && (wr_idx == err_at);
            #1;
            for (int s = 0; s < NS; s++)
                if (dev_ready[s] && s != cur_src) stray++;
            if (dev_ready[cur_src] && dev_valid[cur_src]) rd_idx++;
            if (mem_req && mem_gnt) begin
                chk("R4", "write address", mem_addr, exp_base + 32'(4 * wr_idx));
                chk("R4", "write data", mem_wdata, words[wr_idx % 64]);
                wr_idx++;
            end
        end
    end

    task automatic reg_write(input logic [1:0] idx, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_idx = idx; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] idx, output logic [31:0] d);
        @(negedge clk);
        reg_idx = idx;
        #2;
        d = reg_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        for (int i = 0; i < 3000; i++) begin
            reg_read(2'd3, s);
            if (!s[0]) return;
        end
        chk("R6", "idle timeout", 32'd1, 32'd0);
    endtask

    task automatic launch(int n, int src, bit ie, int gp, int vp, int errk);
        logic [31:0] base;
        for (int i = 0; i < 64; i++) words[i] = $urandom;
        rd_idx = 0; wr_idx = 0; cur_src = src; err_at = errk;
        gnt_pct = gp; val_pct = vp;
        base = $urandom & 32'h0FFF_FFFC;
        exp_base = base;
        reg_write(2'd0, base);
        reg_write(2'd1, 32'(n));
        reg_write(2'd2, ctlword(src, ie, 1'b1));
    endtask

    task automatic finish_check(int n, bit ie, int errk);
        logic [31:0] v;
        wait_idle();
        if (errk < 0 || errk >= n) begin
            chk("R6", "writes made", 32'(wr_idx), 32'(n));
            reg_read(2'd1, v); chk("R5", "final count", v, 32'd0);
            reg_read(2'd0, v); chk("R5", "final address", v, exp_base + 32'(4 * n));
            reg_read(2'd3, v); chk("R6", "status", v, 32'h2);
            reg_read(2'd2, v); chk("R6", "run cleared", {31'd0, v[0]}, 32'd0);
        end else begin
            chk("R7", "writes made", 32'(wr_idx), 32'(errk + 1));
            reg_read(2'd1, v); chk("R7", "count kept", v, 32'(n - errk));
            reg_read(2'd0, v); chk("R7", "address kept", v, exp_base + 32'(4 * errk));
            reg_read(2'd3, v); chk("R7", "status", v, 32'h4);
        end
        chk("R3", "words taken equal writes", 32'(rd_idx), 32'(wr_idx));
        chk("R12", "irq", {31'd0, irq}, {31'd0, ie});
    endtask

    initial begin
        logic [31:0] v;
        int k;
        void'($urandom(32'd4242));
        for (int i = 0; i < 64; i++) words[i] = '0;
        repeat (3) @(negedge clk);
        #1;
        for (int i = 0; i < 4; i++) begin
            reg_idx = 2'(i); #1;
            chk("R1", "reset register", reg_rdata, 32'd0);
        end
        chk("R1", "reset outputs", {29'd0, irq, mem_req, |dev_ready}, 32'd0);
        rst_n = 1'b1;

        // Randomized transfers.
        for (int t = 0; t < 8; t++) begin
            int n, src, gp, vp, ek;
            bit ie;
            n   = 1 + ($urandom % 12);
            src = $urandom % NS;
            ie  = 1'($urandom % 2);
            gp  = 20 + ($urandom % 81);
            vp  = 20 + ($urandom % 81);
            ek  = (($urandom % 4) == 0) ? int'($urandom % n) : -1;
            launch(n, src, ie, gp, vp, ek);
            finish_check(n, ie, ek);
        end

        // R2: start after an error clears the flags.
        launch(6, 1, 1'b1, 60, 80, 2);
        finish_check(6, 1'b1, 2);
        launch(3, 2, 1'b1, 60, 80, -1);
        reg_read(2'd3, v);
        chk("R2", "start clears flags, busy", v, 32'h1);
        finish_check(3, 1'b1, -1);

        // R11: write-one clears, irq drops.
        reg_write(2'd3, 32'h6);
        reg_read(2'd3, v); chk("R11", "w1c status", v, 32'h0);
        chk("R12", "irq after clear", {31'd0, irq}, 32'd0);

        // R12: interrupt disabled.
        launch(2, 0, 1'b0, 100, 100, -1);
        finish_check(2, 1'b0, -1);
        reg_read(2'd3, v); chk("R12", "done without irq", {31'd0, v[1] & !irq}, 32'd1);

        // R8: zero count.
        rd_idx = 0; wr_idx = 0;
        reg_write(2'd1, 32'd0);
        reg_write(2'd2, ctlword(3, 1'b1, 1'b1));
        reg_read(2'd3, v); chk("R8", "zero count status", v, 32'h2);
        chk("R8", "zero count irq", {31'd0, irq}, 32'd1);
        repeat (5) @(negedge clk);
        chk("R8", "zero count writes", 32'(wr_idx), 32'd0);
        reg_read(2'd2, v); chk("R8", "run not set", {31'd0, v[0]}, 32'd0);

        // R9: address and count writes while busy are ignored.
        launch(10, 3, 1'b1, 15, 100, -1);
        reg_read(2'd3, v); chk("R9", "busy during writes", {31'd0, v[0]}, 32'd1);
        reg_write(2'd0, 32'hDEAD_0000);
        reg_write(2'd1, 32'd3);
        finish_check(10, 1'b1, -1);

        // R10: abort while busy.
        launch(30, 1, 1'b1, 25, 90, -1);
        for (int i = 0; i < 2000 && wr_idx < 3; i++) @(negedge clk);
        reg_write(2'd2, ctlword(1, 1'b1, 1'b0));
        wait_idle();
        k = wr_idx;
        chk("R10", "stopped early", 32'(k < 30), 32'd1);
        reg_read(2'd3, v); chk("R10", "abort status", v, 32'h2);
        reg_read(2'd1, v); chk("R10", "remaining count", v, 32'(30 - k));
        reg_read(2'd0, v); chk("R10", "address", v, exp_base + 32'(4 * k));
        chk("R10", "no extra word taken", 32'(rd_idx), 32'(k));

        // R11: completion and clear in the same cycle; set wins.
        launch(1, 0, 1'b1, 0, 100, -1);
        for (int i = 0; i < 200 && !mem_req; i++) begin
            @(negedge clk); #2;
        end
        @(posedge clk); #1;
        force_gnt = 1'b1;
        @(negedge clk);
        reg_wr = 1'b1; reg_idx = 2'd3; reg_wdata = 32'h6;
        @(negedge clk);
        reg_wr = 1'b0; force_gnt = 1'b0;
        reg_read(2'd3, v);
        chk("R11", "set beats clear", v, 32'h2);
        chk("R12", "irq kept", {31'd0, irq}, 32'd1);
        chk("R11", "single write", 32'(wr_idx), 32'd1);

        chk("R3", "ready on unselected stream", 32'(stray), 32'd0);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        tests++; fails++;
        $display("FAIL R6 watchdog: actual hung expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule